// File: doc/BRIEF.md
# Two-Way LRU Cache Directory

This block holds the tag directory and the replacement state for a write-through cache on a 32-bit address. The cache has two ways. Each way has 512 sets, and each set covers eight 32-bit words. For every set, each way stores a tag, one tag-valid flag and eight word-valid flags. A single bit per set records which way was used least recently.

A caller presents one request per cycle: a read lookup, a write lookup, a snoop invalidate or a reserved no-op. One cycle later the block returns a registered response. The response says whether the request hit and in which way. On a read that misses, it also says which way the caller must fill from memory. The directory updates itself in that same cycle, so the next request already sees the new state. A separate flush input invalidates every tag in one cycle.

The data arrays and the memory bus are outside this block.

Top module: `lru2_cache_dir`

## Requirements
- R1: The request address splits into three fields. Bits 31..14 are the tag. Bits 13..5 pick the set. Bits 4..2 pick the word. Bits 1..0 are ignored. All 18 tag bits take part in the compare, and each set keeps its own state.
- R2: Response timing and encoding.
  - A request accepted in cycle N gives `rsp_valid`=1 in cycle N+1, with `rsp_word` equal to address bits 4..2.
  - The op codes are: read 2'b00, write 2'b01, snoop 2'b10, no-op 2'b11.
  - When there is no hit, `rsp_way` reads 0. When there is no fill, `rsp_fill_way` reads 0.
- R3: A read hits when one way has a valid tag equal to the address tag and the addressed word is valid in that way. The response then has `rsp_hit`=1, `rsp_way` set to that way, and `rsp_fill`=0.
- R4: After a read hit, the set's LRU bit names the other way. A later tag miss in that set therefore fills the way that did not hit.
- R5: A read whose tag matches no valid way is a tag miss.
  - It reports `rsp_fill`=1, with `rsp_fill_way` set to the way named by the LRU bit.
  - That way takes the new tag and becomes tag-valid.
  - Only the addressed word is left valid in that way.
  - The LRU bit then names the other way.
- R6: A read whose tag matches a valid way, but whose word is invalid, is a word miss.
  - It fills that same way.
  - It adds only the addressed word-valid bit and keeps the way's other valid words.
  - The LRU bit then names the other way.
- R7: A write that would be a read hit reports `rsp_hit` and the way, and changes neither the directory nor the LRU bit. A write that misses reports no hit and no fill, and allocates nothing.
- R8: A snoop that hits clears only the addressed word-valid bit in the matching way and reports `rsp_hit`. A snoop that misses reports no hit and changes nothing. No snoop changes the LRU bit.
- R9: `flush` clears every tag-valid bit in both ways in one cycle. A request presented in the same cycle is dropped, so the next cycle has `rsp_valid`=0. The LRU bits are kept.
- R10: The reset is synchronous and active high. It clears all tag-valid bits and all LRU bits, so way 0 is the first victim in every set, and it clears `rsp_valid`.
- R11: The no-op code produces a response with no hit and no fill, and changes no state.
- R12: At most one way's valid tag matches any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all tags; drops a request in the same cycle |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 read, 01 write, 10 snoop, 11 no-op |
| req_addr | input | 32 | Byte address of the request |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Request hit a valid word |
| rsp_way | output | 1 | Way that hit |
| rsp_fill | output | 1 | Read missed; caller must fill from memory |
| rsp_fill_way | output | 1 | Way to fill |
| rsp_word | output | 3 | Word index of the request |

## Verification
The bench targets the cases where the two miss kinds differ.

- A word miss in a live way must refill that way, not the LRU victim. A design that confuses the two would evict a live tag and report the wrong fill way.
- A tag replacement must drop the stale words. A design that kept them would report false hits on the replaced tag's neighbours.
- Writes and snoops must not move the LRU bit. A design that let them would pick the wrong victim on the next tag miss.
- Flush and reset are checked for the same reason. A design that dropped the same-cycle request wrongly, or kept LRU state across reset, would choose the wrong fill way afterwards.

// File: rtl/cdir_pkg.sv
package cdir_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SNOOP = 2'b10,
    OP_NOP   = 2'b11
  } cdir_op_e;
endpackage

// File: rtl/cdir_way.sv
// One way of the directory: tag and word-valid arrays (RAM-inferable,
// asynchronous read, one write port each) plus tag-valid flops that flush
// can clear in a single cycle.
module cdir_way #(
  parameter int SET_W  = 9,
  parameter int TAG_W  = 18,
  parameter int WORD_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [SET_W-1:0]  set_idx,
  input  logic [TAG_W-1:0]  tag,
  input  logic [WORD_W-1:0] word,
  input  logic              alloc,
  input  logic              set_word,
  input  logic              clr_word,
  output logic              tag_hit,
  output logic              word_hit
);
  localparam int SETS  = 1 << SET_W;
  localparam int WORDS = 1 << WORD_W;

  logic [TAG_W-1:0] tag_mem [SETS];
  logic [WORDS-1:0] wv_mem  [SETS];
  logic [SETS-1:0]  tv_q;

  logic [TAG_W-1:0] rd_tag;
  logic [WORDS-1:0] rd_wv;
  logic [WORDS-1:0] word_oh;
  logic [WORDS-1:0] wv_next;

  assign rd_tag   = tag_mem[set_idx];
  assign rd_wv    = wv_mem[set_idx];
  assign word_oh  = WORDS'(1) << word;
  assign tag_hit  = tv_q[set_idx] && (rd_tag == tag);
  assign word_hit = tag_hit && rd_wv[word];

  always_comb begin
    if (alloc)         wv_next = word_oh;
    else if (set_word) wv_next = rd_wv | word_oh;
    else               wv_next = rd_wv & ~word_oh;
  end

  always_ff @(posedge clk) begin
    if (alloc) tag_mem[set_idx] <= tag;
  end

  always_ff @(posedge clk) begin
    if (alloc || set_word || clr_word) wv_mem[set_idx] <= wv_next;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) tv_q <= '0;
    else if (alloc)   tv_q[set_idx] <= 1'b1;
  end

  // R5: an allocated set is tag-valid on the following cycle
  a_r5_alloc_marks_valid: assert property (@(posedge clk) disable iff (rst)
    (alloc && !flush) |=> tv_q[$past(set_idx)]);
endmodule

// File: rtl/cdir_lru.sv
// One LRU bit per set; the bit names the way to evict next.
module cdir_lru #(
  parameter int SET_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] set_idx,
  input  logic             we,
  input  logic             wval,
  output logic             victim
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0] lru_q;

  assign victim = lru_q[set_idx];

  always_ff @(posedge clk) begin
    if (rst)     lru_q <= '0;
    else if (we) lru_q[set_idx] <= wval;
  end
endmodule

// File: rtl/cdir_decide.sv
// Per-request decision: hit/miss classification, directory write enables
// and LRU update.
module cdir_decide
  import cdir_pkg::*;
(
  input  logic       valid,
  input  cdir_op_e   op,
  input  logic [1:0] tag_hit,
  input  logic [1:0] word_hit,
  input  logic       victim,
  output logic [1:0] alloc,
  output logic [1:0] set_word,
  output logic [1:0] clr_word,
  output logic       lru_we,
  output logic       lru_val,
  output logic       hit,
  output logic       hit_way,
  output logic       fill,
  output logic       fill_way
);
  logic any_word, any_tag, wway, tway;

  assign any_word = |word_hit;
  assign any_tag  = |tag_hit;
  assign wway     = word_hit[1];
  assign tway     = tag_hit[1];

  always_comb begin
    alloc    = '0;
    set_word = '0;
    clr_word = '0;
    lru_we   = 1'b0;
    lru_val  = 1'b0;
    hit      = 1'b0;
    hit_way  = 1'b0;
    fill     = 1'b0;
    fill_way = 1'b0;
    if (valid) begin
      unique case (op)
        OP_READ: begin
          lru_we = 1'b1;
          if (any_word) begin
            hit     = 1'b1;
            hit_way = wway;
            lru_val = ~wway;
          end else if (any_tag) begin
            fill           = 1'b1;
            fill_way       = tway;
            set_word[tway] = 1'b1;
            lru_val        = ~tway;
          end else begin
            fill          = 1'b1;
            fill_way      = victim;
            alloc[victim] = 1'b1;
            lru_val       = ~victim;
          end
        end
        OP_WRITE: begin
          if (any_word) begin
            hit     = 1'b1;
            hit_way = wway;
          end
        end
        OP_SNOOP: begin
          if (any_word) begin
            hit            = 1'b1;
            hit_way        = wway;
            clr_word[wway] = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lru2_cache_dir.sv
module lru2_cache_dir
  import cdir_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SET_W  = 9,
  parameter int WORD_W = 3,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_way,
  output logic              rsp_fill,
  output logic              rsp_fill_way,
  output logic [WORD_W-1:0] rsp_word
);
  localparam int TAG_W  = ADDR_W - SET_W - WORD_W - OFF_W;
  localparam int NWAYS  = 2;
  localparam int TAG_LO = SET_W + WORD_W + OFF_W;
  localparam int SET_LO = WORD_W + OFF_W;

  logic [TAG_W-1:0]  a_tag;
  logic [SET_W-1:0]  a_set;
  logic [WORD_W-1:0] a_word;
  logic [OFF_W-1:0]  unused_offset;
  cdir_op_e          op;
  logic              accept;

  assign a_tag         = req_addr[ADDR_W-1:TAG_LO];
  assign a_set         = req_addr[TAG_LO-1:SET_LO];
  assign a_word        = req_addr[SET_LO-1:OFF_W];
  assign unused_offset = req_addr[OFF_W-1:0];
  assign op            = cdir_op_e'(req_op);
  assign accept        = req_valid && !flush;

  logic [NWAYS-1:0] tag_hit, word_hit, alloc, set_word, clr_word;
  logic victim, lru_we, lru_val, hit, hit_way, fill, fill_way;

  for (genvar g = 0; g < NWAYS; g++) begin : g_way
    cdir_way #(.SET_W(SET_W), .TAG_W(TAG_W), .WORD_W(WORD_W)) u_way (
      .clk      (clk),
      .rst      (rst),
      .flush    (flush),
      .set_idx  (a_set),
      .tag      (a_tag),
      .word     (a_word),
      .alloc    (alloc[g]),
      .set_word (set_word[g]),
      .clr_word (clr_word[g]),
      .tag_hit  (tag_hit[g]),
      .word_hit (word_hit[g])
    );
  end

  cdir_lru #(.SET_W(SET_W)) u_lru (
    .clk     (clk),
    .rst     (rst),
    .set_idx (a_set),
    .we      (lru_we),
    .wval    (lru_val),
    .victim  (victim)
  );

  cdir_decide u_decide (
    .valid    (accept),
    .op       (op),
    .tag_hit  (tag_hit),
    .word_hit (word_hit),
    .victim   (victim),
    .alloc    (alloc),
    .set_word (set_word),
    .clr_word (clr_word),
    .lru_we   (lru_we),
    .lru_val  (lru_val),
    .hit      (hit),
    .hit_way  (hit_way),
    .fill     (fill),
    .fill_way (fill_way)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_way      <= 1'b0;
      rsp_fill     <= 1'b0;
      rsp_fill_way <= 1'b0;
      rsp_word     <= '0;
    end else begin
      rsp_valid    <= accept;
      rsp_hit      <= hit;
      rsp_way      <= hit_way;
      rsp_fill     <= fill;
      rsp_fill_way <= fill_way;
      rsp_word     <= accept ? a_word : '0;
    end
  end

  // R12: the two ways never hold the same valid tag for one set
  a_r12_single_match: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $onehot0(tag_hit));

  // R9: after a flush no way matches any address
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (tag_hit == '0));

  // R5/R6: a read without a valid word must request a fill
  a_r5_read_miss_fills: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_READ && word_hit == '0) |=> (rsp_valid && rsp_fill));

  // R7: writes never request a fill
  a_r7_write_no_fill: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_WRITE) |=> !rsp_fill);

  // R2: a dropped or absent request leaves no response
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !rsp_valid);
endmodule

// File: tb/tb_lru2_cache_dir.sv
`timescale 1ns/1ps
module tb_lru2_cache_dir;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_way, rsp_fill, rsp_fill_way;
  logic [2:0]  rsp_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lru2_cache_dir dut (
    .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid),
    .req_op(req_op), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_fill(rsp_fill),
    .rsp_fill_way(rsp_fill_way), .rsp_word(rsp_word)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;
    logic        hit;
    logic        way;
    logic        fill;
    logic        fway;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  // op: 0 read, 1 write, 2 snoop, 3 no-op. Set 3 unless noted.
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'h0000_4060, 1'b0, 1'b0, 1'b1, 1'b0, 8'd5},  // R5 tag miss, victim way0
    '{2'd0, 32'h0000_4060, 1'b1, 1'b0, 1'b0, 1'b0, 8'd3},  // R3 hit way0
    '{2'd0, 32'h0000_4064, 1'b0, 1'b0, 1'b1, 1'b0, 8'd6},  // R6 word miss refills way0
    '{2'd0, 32'h0000_4060, 1'b1, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 earlier word kept
    '{2'd0, 32'h0000_8068, 1'b0, 1'b0, 1'b1, 1'b1, 8'd5},  // R5 victim way1
    '{2'd0, 32'h0000_8068, 1'b1, 1'b1, 1'b0, 1'b0, 8'd3},  // R3 hit way1
    '{2'd0, 32'h0000_4064, 1'b1, 1'b0, 1'b0, 1'b0, 8'd4},  // R4 hit way0, LRU->1
    '{2'd0, 32'h0000_C060, 1'b0, 1'b0, 1'b1, 1'b1, 8'd4},  // R4 victim is way1
    '{2'd0, 32'h0000_8068, 1'b0, 1'b0, 1'b1, 1'b0, 8'd5},  // R5 evicted tag misses
    '{2'd1, 32'h0000_C060, 1'b1, 1'b1, 1'b0, 1'b0, 8'd7},  // R7 write hit way1
    '{2'd0, 32'h0000_4074, 1'b0, 1'b0, 1'b1, 1'b1, 8'd7},  // R7 LRU untouched: way1
    '{2'd1, 32'h0000_806C, 1'b0, 1'b0, 1'b0, 1'b0, 8'd7},  // R7 write miss
    '{2'd0, 32'h0000_806C, 1'b0, 1'b0, 1'b1, 1'b0, 8'd7},  // R7 nothing allocated
    '{2'd2, 32'h0000_4074, 1'b1, 1'b1, 1'b0, 1'b0, 8'd8},  // R8 snoop hit way1
    '{2'd0, 32'h0000_4074, 1'b0, 1'b0, 1'b1, 1'b1, 8'd8},  // R8 word cleared
    '{2'd2, 32'h0000_807C, 1'b0, 1'b0, 1'b0, 1'b0, 8'd8},  // R8 snoop miss
    '{2'd0, 32'h0000_8068, 1'b1, 1'b0, 1'b0, 1'b0, 8'd8},  // R8 other words kept
    '{2'd3, 32'h0000_8068, 1'b0, 1'b0, 1'b0, 1'b0, 8'd11}, // R11 no-op
    '{2'd0, 32'h0000_7FE0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd1},  // R1 set 511 independent
    '{2'd0, 32'h0000_7FE3, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1},  // R1 byte bits ignored
    '{2'd0, 32'h8000_4060, 1'b0, 1'b0, 1'b1, 1'b1, 8'd1}   // R1 top tag bit compared
  };

  task automatic chk(input int r, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: {valid,hit,way,fill,fway,word} act=%b exp=%b", r, act, exp);
    end
  endtask

  function automatic logic [7:0] pack_rsp();
    return {rsp_valid, rsp_hit, rsp_way, rsp_fill, rsp_fill_way, rsp_word};
  endfunction

  task automatic run_req(input logic [1:0] op, input logic [31:0] addr, input logic f);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = addr;
    flush     = f;
    @(negedge clk);
    req_valid = 1'b0;
    flush     = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(10, {7'd0, rsp_valid}, 8'd0);  // R10 reset state
    rst = 1'b0;
    @(negedge clk);
    chk(10, {7'd0, rsp_valid}, 8'd0);  // R10 idle after reset

    for (int i = 0; i < NV; i++) begin
      run_req(VECS[i].op, VECS[i].addr, 1'b0);
      chk(int'(VECS[i].req), pack_rsp(),
          {1'b1, VECS[i].hit, VECS[i].way, VECS[i].fill, VECS[i].fway,
           VECS[i].addr[4:2]});  // R2 timing and word field
    end

    // R9: flush drops the request presented with it
    run_req(2'd0, 32'h0000_8068, 1'b1);
    chk(9, pack_rsp(), 8'd0);
    // R9: all tags gone, LRU for set 3 still names way0
    run_req(2'd0, 32'h0000_8068, 1'b0);
    chk(9, pack_rsp(), {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd2});

    // R10: reset mid-run clears LRU (set 3 pointed at way1) and tags
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(10, {7'd0, rsp_valid}, 8'd0);
    rst = 1'b0;
    run_req(2'd0, 32'h0000_8068, 1'b0);
    chk(10, pack_rsp(), {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd2});

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule